// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. It captures a word address on the rising clock edge whenever one of two load strobes is accepted. From that start address it then produces the later beats of a four-beat burst by itself, moving on one beat only in cycles where the step input is high. Only the low two address bits take part in the burst. The upper bits stay fixed until the next load.

A static order input chooses how the low bits move. In the wrapping-count order they add the beat number to the start value, modulo four. In the XOR order they combine the start value with the beat number by exclusive OR. Callers do not have to use bursts: a new address can be loaded on every cycle, and each one appears at the output on the following cycle. The address flows straight through under strobe control, with no back-pressure. For that reason every pin is a plain control or data pin and none uses a handshake.

The burst flag is set by every load. It falls when the fourth step wraps the sequence back to the start address.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, clears the output address to zero and drops the burst flag in the cycle that follows.
- R2: When the primary strobe is high and the chip enable is high at a rising edge, the next cycle shows the input address on `addr_o` unchanged, and `burst_o` is high.
- R3: The primary strobe has no effect while the chip enable is low. With the secondary strobe also low, the sequencer then holds or steps exactly as if no strobe were present.
- R4: The secondary strobe loads the input address whatever the chip enable level, with the same result as R2.
- R5: A load takes priority over the step input in the same cycle, so a load with step high still shows beat 0. When both strobes are accepted together, a single load of the input address takes place.
- R6: Without an accepted strobe, a high step input moves one beat forward, and a low step input leaves `addr_o` and `burst_o` unchanged.
- R7: With `order_lin_i` = 1, the low two bits on beat n (n = 0..3) equal (start + n) mod 4.
- R8: With `order_lin_i` = 0 (the default order), the low two bits on beat n equal start XOR n.
- R9: Bits above the low two never change between loads.
- R10: The fourth step after a load returns `addr_o` to the start address and clears `burst_o`.
- R11: Loads on consecutive cycles each take effect, so a different address appears on every cycle with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Chip enable; gates the primary strobe only |
| ld_pri_i | input | 1 | Primary load strobe |
| ld_sec_i | input | 1 | Secondary load strobe, not gated by the enable |
| step_i | input | 1 | Advance the burst by one beat |
| order_lin_i | input | 1 | 1 = wrapping-count order, 0 = XOR order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current word address |
| burst_o | output | 1 | High from a load until the burst wraps |

## Verification
The bench loads start values that are not zero in both orders. A design that swapped or mixed the two orders would then show a wrong third or fourth beat, and a design that let a carry ripple into the upper bits would change the upper field on the wrap. It loads with step held high, to catch a design that advanced in the load cycle. It also pulses the primary strobe with the enable low, both with and without a step, so that a design that let the enable gate the wrong strobe either loses the secondary load or takes a primary load it should ignore. Finally, it issues loads on consecutive cycles and a reset in the middle of a burst, which catch a pipeline that drops a cycle and a flag left stale after reset.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic {
    ORD_XOR  = 1'b0,
    ORD_WRAP = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STEP = 2'd1,
    CMD_LOAD = 2'd2
  } seq_cmd_e;

endpackage

// File: rtl/bas_strobe_dec.sv
module bas_strobe_dec
  import burst_addr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ce_i,
  input  logic     ld_pri_i,
  input  logic     ld_sec_i,
  input  logic     step_i,
  output seq_cmd_e cmd_o
);

  logic pri_ok;

  always_comb begin
    pri_ok = ld_pri_i & ce_i;
    // primary checked first: it wins when both strobes arrive together
    if (pri_ok)        cmd_o = CMD_LOAD;
    else if (ld_sec_i) cmd_o = CMD_LOAD;
    else if (step_i)   cmd_o = CMD_STEP;
    else               cmd_o = CMD_HOLD;
  end

  // R3: a gated-off primary strobe alone never produces a load
  p_pri_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce_i && !ld_sec_i) |-> (cmd_o != CMD_LOAD));

  // R5: load wins over step
  p_load_over_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_sec_i && step_i) |-> (cmd_o == CMD_LOAD));

endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import burst_addr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_cmd_e         cmd_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] beat_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      busy_q <= 1'b0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: begin
          beat_q <= '0;
          busy_q <= 1'b1;
        end
        CMD_STEP: begin
          beat_q <= beat_q + ONE;
          if (beat_q == LAST) busy_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign beat_o = beat_q;
  assign busy_o = busy_q;

  // R6: no command keeps the state
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_HOLD) |=> ($stable(beat_o) && $stable(busy_o)));

  // R6: a step moves exactly one beat
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_STEP) |=> (beat_o == $past(beat_o) + ONE));

  // R2: load restarts at beat 0 with the flag set
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_LOAD) |=> (beat_o == '0 && busy_o));

  // R10: the wrapping step ends the burst
  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_STEP && beat_o == LAST) |=> !busy_o);

endmodule

// File: rtl/bas_base_reg.sv
module bas_base_reg
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_cmd_e          cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);

  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)                    base_q <= '0;
    else if (cmd_i == CMD_LOAD) base_q <= addr_i;
  end

  assign base_o = base_q;

  // R9: the stored start only changes on a load
  p_base_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_i != CMD_LOAD) |=> $stable(base_o));

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import burst_addr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] beat_i,
  input  order_e           order_i,
  output logic [CNT_W-1:0] low_o
);

  logic [CNT_W-1:0] wrap_low;
  logic [CNT_W-1:0] xor_low;

  // sum kept to CNT_W bits so the carry never reaches the upper field
  assign wrap_low = start_i + beat_i;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign xor_low[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    low_o = (order_i == ORD_WRAP) ? wrap_low : xor_low;
  end

  // R8: beat 0 maps to the start value in either order
  always_comb begin
    if (beat_i == '0) p_beat0_start_r8: assert (low_o == start_i);
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_i,
  input  logic              ld_pri_i,
  input  logic              ld_sec_i,
  input  logic              step_i,
  input  logic              order_lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_o
);

  localparam int UP_W = ADDR_W - CNT_W;

  seq_cmd_e          cmd;
  logic [CNT_W-1:0]  beat;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  low;
  order_e            order;

  assign order = order_e'(order_lin_i);

  bas_strobe_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .ce_i     (ce_i),
    .ld_pri_i (ld_pri_i),
    .ld_sec_i (ld_sec_i),
    .step_i   (step_i),
    .cmd_o    (cmd)
  );

  bas_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd),
    .beat_o (beat),
    .busy_o (burst_o)
  );

  bas_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd),
    .addr_i (addr_i),
    .base_o (base)
  );

  bas_order_map #(.CNT_W(CNT_W)) u_map (
    .start_i (base[CNT_W-1:0]),
    .beat_i  (beat),
    .order_i (order),
    .low_o   (low)
  );

  assign addr_o = {base[ADDR_W-1:CNT_W], low};

  // R1: reset clears address and flag
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && !burst_o));

  // R4: secondary strobe loads regardless of enable
  p_sec_load_r4: assert property (@(posedge clk) disable iff (rst)
    ld_sec_i |=> (addr_o == $past(addr_i) && burst_o));

  // R2: enabled primary strobe loads
  p_pri_load_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_pri_i && ce_i) |=> (addr_o == $past(addr_i)));

  // R9: upper field fixed without a load
  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    (!ld_sec_i && !(ld_pri_i && ce_i)) |=>
      (addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W])));

  // R6: idle cycle keeps the output
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld_sec_i && !(ld_pri_i && ce_i) && !step_i) |=> $stable(addr_o));

  initial begin
    p_width_ok: assert (UP_W > 0);
  end

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b0, lp = 1'b0, ls = 1'b0, st = 1'b0, lin = 1'b0;
  logic [AW-1:0] ain = '0;
  logic [AW-1:0] aout;
  logic          bflag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq uut (
    .clk(clk), .rst(rst), .ce_i(ce), .ld_pri_i(lp), .ld_sec_i(ls),
    .step_i(st), .order_lin_i(lin), .addr_i(ain),
    .addr_o(aout), .burst_o(bflag)
  );

  task automatic check(string req, logic [AW-1:0] ea, logic eb);
    n_chk++;
    if (aout !== ea || bflag !== eb) begin
      n_err++;
      $display("FAIL %s: addr=%h burst=%b expected addr=%h burst=%b",
               req, aout, bflag, ea, eb);
    end
  endtask

  // drive at negedge, let one posedge pass, return at next negedge
  task automatic cyc(logic c, logic p, logic s, logic a, logic [AW-1:0] ad);
    ce = c; lp = p; ls = s; st = a; ain = ad;
    @(posedge clk);
    @(negedge clk);
    ce = 0; lp = 0; ls = 0; st = 0; ain = '0;
  endtask

  task automatic t_reset();
    rst = 1; cyc(0, 0, 0, 0, '0); rst = 0;
    check("R1 reset", 20'h0, 1'b0);
  endtask

  task automatic t_linear();
    lin = 1;
    cyc(1, 1, 0, 0, 20'h12345);
    check("R2 primary load", 20'h12345, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R7 beat1", 20'h12346, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R7 beat2", 20'h12347, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R7 R9 beat3", 20'h12344, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R10 wrap linear", 20'h12345, 1'b0);
  endtask

  task automatic t_interleave();
    lin = 0;
    cyc(1, 1, 0, 0, 20'hABCDE);
    check("R8 beat0", 20'hABCDE, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R8 beat1", 20'hABCDF, 1'b1);
    cyc(0, 0, 0, 0, '0); check("R6 hold", 20'hABCDF, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R8 beat2", 20'hABCDC, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R8 beat3", 20'hABCDD, 1'b1);
    cyc(0, 0, 0, 1, '0); check("R10 wrap xor", 20'hABCDE, 1'b0);
  endtask

  task automatic t_gate();
    lin = 1;
    cyc(1, 1, 0, 0, 20'h40001);
    cyc(0, 1, 0, 0, 20'h7777A);
    check("R3 ignored hold", 20'h40001, 1'b1);
    cyc(0, 1, 0, 1, 20'h7777A);
    check("R3 ignored step", 20'h40002, 1'b1);
    cyc(0, 0, 1, 0, 20'h55557);
    check("R4 secondary load", 20'h55557, 1'b1);
  endtask

  task automatic t_priority();
    lin = 1;
    cyc(1, 1, 1, 1, 20'h00003);
    check("R5 both strobes with step", 20'h00003, 1'b1);
    cyc(0, 0, 0, 1, '0);
    check("R5 R7 next beat", 20'h00000, 1'b1);
    cyc(0, 0, 1, 1, 20'hFFFFE);
    check("R5 secondary with step", 20'hFFFFE, 1'b1);
  endtask

  task automatic t_b2b();
    lin = 0;
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 0, 0, 20'h10000 * (k + 1) + k);
      check("R11 back to back", 20'h10000 * (k + 1) + k, 1'b1);
    end
  endtask

  task automatic t_mid_reset();
    cyc(0, 0, 1, 0, 20'h2468B);
    cyc(0, 0, 0, 1, '0);
    rst = 1; cyc(0, 0, 0, 1, '0); rst = 0;
    check("R1 mid burst reset", 20'h0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_linear();
    t_interleave();
    t_gate();
    t_priority();
    t_b2b();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule